// File: doc/BRIEF.md
# Power-Good Strap Capture and Clock Routing Decoder

This block sits at the front of a clock generator and fixes its configuration at power-up. It watches an active-low power-good input and takes a single snapshot of six strap pins: three CPU frequency-select bits, two function-select bits and one debug-port select bit. The snapshot is taken when a synchronized, filtered low on power-good is first accepted. From then on the snapshot is frozen, and later activity on power-good or on the strap pins has no effect. The only exception is test mode, in which the snapshot follows the pins again for as long as power-good stays accepted low.

The captured straps are decoded into selects that steer clock sources onto shared output pin pairs, and into a CPU frequency code for the synthesizer. Until a capture happens, every decoded output stays at a safe default. A frequency-select pattern that the frequency table does not define raises a flag and falls back to the lowest CPU frequency.

Top module: `strap_cfg`

## Requirements
- R1: After reset and before any capture: latched_o=0, all captured strap outputs are 0, pair_a_sel_o=0 (dot clock), pair_b_sel_o=0 (100 MHz spread), shared_sel_o=0 (SRC10), cpu_freq_o=0 (100 MHz) and fs_invalid_o=0.
- R2: pwrgd_ni passes through a 2-flop synchronizer and is accepted low only when two consecutive synchronized samples are low. A low that starts before clock edge 1 and stays low captures on edge 4. A low that lasts a single cycle never captures.
- R3: On an accepted low, fs_i (bit 2=FSC, bit 1=FSB, bit 0=FSA), fsel_i and itp_sel_i are all stored into fs_q_o, fsel_q_o and itp_q_o in the same cycle, and latched_o rises and then stays high.
- R4: Once latched_o is high and test_mode_i is low, changes on pwrgd_ni, fs_i, fsel_i and itp_sel_i leave every output unchanged.
- R5: While test_mode_i is high and power-good is accepted low, the straps are captured again on every clock edge. After test_mode_i falls, the values freeze.
- R6: pair_a_sel_o follows the captured fsel: 00 and 01 give 0 (96 MHz dot clock), 10 gives 1 (27 MHz non-spread/spread), and 11 gives 2 (pair off, driven low).
- R7: pair_b_sel_o is 0 (100 MHz spread clock) when the captured fsel is 00, and 1 (SRC0) for any other value.
- R8: shared_sel_o equals the captured ITP select bit: 0 routes SRC10 and 1 routes CPU2_ITP.
- R9: cpu_freq_o decodes the captured fs as follows: 101 gives 0 (100 MHz), 001 gives 1 (133 MHz), 011 gives 2 (166 MHz) and 010 gives 3 (200 MHz).
- R10: Any other captured fs value (000, 100, 110, 111) sets fs_invalid_o=1 and cpu_freq_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwrgd_ni | input | 1 | Active-low power-good, asynchronous |
| fs_i | input | 3 | Raw frequency straps {FSC,FSB,FSA} |
| fsel_i | input | 2 | Raw function-select straps |
| itp_sel_i | input | 1 | Raw debug-port pin-pair select strap |
| test_mode_i | input | 1 | Lifts the one-shot lock |
| latched_o | output | 1 | Straps have been captured |
| fs_q_o | output | 3 | Captured frequency straps |
| fsel_q_o | output | 2 | Captured function-select straps |
| itp_q_o | output | 1 | Captured debug-port select |
| pair_a_sel_o | output | 2 | First shared pair source: 0 dot, 1 27 MHz, 2 off |
| pair_b_sel_o | output | 1 | Second shared pair source: 0 spread 100 MHz, 1 SRC0 |
| shared_sel_o | output | 1 | Shared pin pair source: 0 SRC10, 1 CPU2_ITP |
| cpu_freq_o | output | 2 | CPU frequency code: 0 100, 1 133, 2 166, 3 200 MHz |
| fs_invalid_o | output | 1 | Captured frequency code is undefined |

## Verification
All 64 strap combinations are captured from reset one at a time. This separates every function-select routing case, both debug-port routes, and all eight frequency patterns, valid and undefined. For each combination the outputs are checked one edge before and one edge on the expected capture edge, which pins down the synchronizer-plus-filter latency. After capture, every strap is inverted and power-good is cycled, to show the lock holds. Separate runs apply a single-cycle power-good glitch, which must not capture, and a test-mode sequence, which must re-capture each cycle and then freeze when test mode is dropped.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int FS_W   = 3;
  localparam int FSEL_W = 2;

  typedef struct packed {
    logic [FS_W-1:0]   fs;
    logic [FSEL_W-1:0] fsel;
    logic              itp;
  } strap_t;

  localparam int STRAP_W = $bits(strap_t);

  typedef enum logic [1:0] {PA_DOT96 = 2'd0, PA_27M = 2'd1, PA_OFF = 2'd2} pair_a_e;
  typedef enum logic {PB_SPREAD100 = 1'b0, PB_SRC0 = 1'b1} pair_b_e;
  typedef enum logic {SH_SRC10 = 1'b0, SH_CPU_ITP = 1'b1} shared_e;
  typedef enum logic [1:0] {CPU_100 = 2'd0, CPU_133 = 2'd1, CPU_166 = 2'd2, CPU_200 = 2'd3} cpu_freq_e;
endpackage

// File: rtl/pg_filter.sv
// Synchronizes active-low power-good and qualifies a low that persists.
module pg_filter #(
  parameter int SYNC_STAGES    = 2,
  parameter int STABLE_SAMPLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwrgd_ni,
  output logic low_ok_o
);
  localparam int HIST_W = (STABLE_SAMPLES > 1) ? STABLE_SAMPLES - 1 : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HIST_W-1:0]      hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pwrgd_ni};
  end

  logic pg_s;
  assign pg_s = sync_q[SYNC_STAGES-1];

  generate
    if (STABLE_SAMPLES > 1) begin : g_hist
      if (HIST_W > 1) begin : g_multi
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) hist_q <= '1;
          else         hist_q <= {hist_q[HIST_W-2:0], pg_s};
        end
      end else begin : g_single
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) hist_q <= '1;
          else         hist_q <= pg_s;
        end
      end
      assign low_ok_o = !pg_s && !(|hist_q);
    end else begin : g_nohist
      assign hist_q   = '0;
      assign low_ok_o = !pg_s;
    end
  endgenerate
endmodule

// File: rtl/strap_capture.sv
// One-shot strap register; test mode reopens it.
module strap_capture
  import strap_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   low_ok_i,
  input  logic   test_mode_i,
  input  strap_t straps_i,
  output strap_t straps_o,
  output logic   latched_o
);
  logic take;
  assign take = low_ok_i && (!latched_o || test_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      straps_o  <= '0;
      latched_o <= 1'b0;
    end else if (take) begin
      straps_o  <= straps_i;
      latched_o <= 1'b1;
    end
  end
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_pkg::*;
(
  input  logic      latched_i,
  input  strap_t    straps_i,
  output pair_a_e   pair_a_o,
  output pair_b_e   pair_b_o,
  output shared_e   shared_o,
  output cpu_freq_e cpu_freq_o,
  output logic      fs_invalid_o
);
  always_comb begin
    pair_a_o     = PA_DOT96;
    pair_b_o     = PB_SPREAD100;
    shared_o     = SH_SRC10;
    cpu_freq_o   = CPU_100;
    fs_invalid_o = 1'b0;
    if (latched_i) begin
      case (straps_i.fsel)
        2'b00, 2'b01: pair_a_o = PA_DOT96;
        2'b10:        pair_a_o = PA_27M;
        default:      pair_a_o = PA_OFF;
      endcase
      pair_b_o = (straps_i.fsel == 2'b00) ? PB_SPREAD100 : PB_SRC0;
      shared_o = straps_i.itp ? SH_CPU_ITP : SH_SRC10;
      case (straps_i.fs)
        3'b101:  cpu_freq_o = CPU_100;
        3'b001:  cpu_freq_o = CPU_133;
        3'b011:  cpu_freq_o = CPU_166;
        3'b010:  cpu_freq_o = CPU_200;
        default: fs_invalid_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/strap_cfg.sv
module strap_cfg
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int STABLE_SAMPLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwrgd_ni,
  input  logic [FS_W-1:0]   fs_i,
  input  logic [FSEL_W-1:0] fsel_i,
  input  logic              itp_sel_i,
  input  logic              test_mode_i,
  output logic              latched_o,
  output logic [FS_W-1:0]   fs_q_o,
  output logic [FSEL_W-1:0] fsel_q_o,
  output logic              itp_q_o,
  output logic [1:0]        pair_a_sel_o,
  output logic              pair_b_sel_o,
  output logic              shared_sel_o,
  output logic [1:0]        cpu_freq_o,
  output logic              fs_invalid_o
);
  logic      low_ok;
  strap_t    raw, held;
  pair_a_e   pa;
  pair_b_e   pb;
  shared_e   sh;
  cpu_freq_e cf;

  assign raw = '{fs: fs_i, fsel: fsel_i, itp: itp_sel_i};

  pg_filter #(
    .SYNC_STAGES   (SYNC_STAGES),
    .STABLE_SAMPLES(STABLE_SAMPLES)
  ) i_pg_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwrgd_ni(pwrgd_ni),
    .low_ok_o(low_ok)
  );

  strap_capture i_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .low_ok_i   (low_ok),
    .test_mode_i(test_mode_i),
    .straps_i   (raw),
    .straps_o   (held),
    .latched_o  (latched_o)
  );

  strap_decode i_decode (
    .latched_i   (latched_o),
    .straps_i    (held),
    .pair_a_o    (pa),
    .pair_b_o    (pb),
    .shared_o    (sh),
    .cpu_freq_o  (cf),
    .fs_invalid_o(fs_invalid_o)
  );

  assign fs_q_o       = held.fs;
  assign fsel_q_o     = held.fsel;
  assign itp_q_o      = held.itp;
  assign pair_a_sel_o = pa;
  assign pair_b_sel_o = pb;
  assign shared_sel_o = sh;
  assign cpu_freq_o   = cf;
endmodule

// File: rtl/strap_cfg_chk.sv
module strap_cfg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwrgd_ni,
  input logic [2:0] fs_i,
  input logic [1:0] fsel_i,
  input logic       itp_sel_i,
  input logic       test_mode_i,
  input logic       latched_o,
  input logic [2:0] fs_q_o,
  input logic [1:0] fsel_q_o,
  input logic       itp_q_o,
  input logic [1:0] pair_a_sel_o,
  input logic       pair_b_sel_o,
  input logic       shared_sel_o,
  input logic [1:0] cpu_freq_o,
  input logic       fs_invalid_o
);
  assert_defaults_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latched_o |-> (pair_a_sel_o == 2'd0 && !pair_b_sel_o && !shared_sel_o &&
                    cpu_freq_o == 2'd0 && !fs_invalid_o));

  assert_filtered_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latched_o) |-> (!$past(pwrgd_ni, 3) && !$past(pwrgd_ni, 4)));

  assert_latched_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_o |=> latched_o);

  assert_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_o && !test_mode_i) |=> ($stable(fs_q_o) && $stable(fsel_q_o) && $stable(itp_q_o)));

  assert_pair_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_o && fsel_q_o == 2'b11) |-> pair_a_sel_o == 2'd2);

  assert_pair_b_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_o |-> (pair_b_sel_o == (fsel_q_o != 2'b00)));

  assert_shared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_o |-> (shared_sel_o == itp_q_o));

  assert_invalid_fallback_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_invalid_o |-> (cpu_freq_o == 2'd0 && latched_o));
endmodule

bind strap_cfg strap_cfg_chk i_strap_cfg_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwrgd_ni(pwrgd_ni), .fs_i(fs_i), .fsel_i(fsel_i),
  .itp_sel_i(itp_sel_i), .test_mode_i(test_mode_i), .latched_o(latched_o),
  .fs_q_o(fs_q_o), .fsel_q_o(fsel_q_o), .itp_q_o(itp_q_o), .pair_a_sel_o(pair_a_sel_o),
  .pair_b_sel_o(pair_b_sel_o), .shared_sel_o(shared_sel_o), .cpu_freq_o(cpu_freq_o),
  .fs_invalid_o(fs_invalid_o)
);

// File: tb/test_strap_cfg.sv
`timescale 1ns/1ps
module test_strap_cfg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwrgd_ni = 1'b1;
  logic [2:0] fs_i = '0;
  logic [1:0] fsel_i = '0;
  logic       itp_sel_i = 1'b0;
  logic       test_mode_i = 1'b0;
  logic       latched_o;
  logic [2:0] fs_q_o;
  logic [1:0] fsel_q_o;
  logic       itp_q_o;
  logic [1:0] pair_a_sel_o;
  logic       pair_b_sel_o;
  logic       shared_sel_o;
  logic [1:0] cpu_freq_o;
  logic       fs_invalid_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk_i = ~clk_i;

  strap_cfg i_strap_cfg (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_pa(input int fsel);
    return (fsel < 2) ? 0 : fsel - 1;
  endfunction

  function automatic int exp_cpu(input int fs);
    case (fs)
      5: return 0;
      1: return 1;
      3: return 2;
      2: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_inv(input int fs);
    return (fs == 5 || fs == 1 || fs == 3 || fs == 2) ? 0 : 1;
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0; pwrgd_ni = 1'b1; test_mode_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic apply(input int v);
    fs_i = v[5:3]; fsel_i = v[2:1]; itp_sel_i = v[0];
  endtask

  task automatic check_decoded(input int v, input string tag);
    int fs = (v >> 3) & 7;
    int fsel = (v >> 1) & 3;
    int itp = v & 1;
    chk("R3", {tag, " latched"}, latched_o, 1);
    chk("R3", {tag, " fs_q"}, fs_q_o, fs);
    chk("R3", {tag, " fsel_q"}, fsel_q_o, fsel);
    chk("R3", {tag, " itp_q"}, itp_q_o, itp);
    chk("R6", {tag, " pair_a"}, pair_a_sel_o, exp_pa(fsel));
    chk("R7", {tag, " pair_b"}, pair_b_sel_o, (fsel != 0) ? 1 : 0);
    chk("R8", {tag, " shared"}, shared_sel_o, itp);
    chk("R9", {tag, " cpu_freq"}, cpu_freq_o, exp_cpu(fs));
    chk("R10", {tag, " invalid"}, fs_invalid_o, exp_inv(fs));
  endtask

  initial begin
    // full strap sweep
    for (int v = 0; v < 64; v++) begin
      apply(v);
      do_reset();
      chk("R1", "latched", latched_o, 0);
      chk("R1", "straps", {fs_q_o, fsel_q_o, itp_q_o}, 0);
      chk("R1", "routing", {pair_a_sel_o, pair_b_sel_o, shared_sel_o}, 0);
      chk("R1", "cpu/inv", {cpu_freq_o, fs_invalid_o}, 0);
      pwrgd_ni = 1'b0;
      repeat (3) @(posedge clk_i);
      @(negedge clk_i);
      chk("R2", "not yet latched after 3 edges", latched_o, 0);
      @(negedge clk_i);
      chk("R2", "latched on edge 4", latched_o, 1);
      check_decoded(v, "sweep");
      // lock: invert straps, cycle power-good
      apply(v ^ 63);
      pwrgd_ni = 1'b1;
      repeat (4) @(negedge clk_i);
      pwrgd_ni = 1'b0;
      repeat (6) @(negedge clk_i);
      chk("R4", "frozen straps", {fs_q_o, fsel_q_o, itp_q_o}, v);
      chk("R4", "frozen cpu", cpu_freq_o, exp_cpu((v >> 3) & 7));
    end

    // single-cycle glitch must not capture; two-cycle low must
    apply(6'b010_11_1);
    do_reset();
    pwrgd_ni = 1'b0;
    @(negedge clk_i);
    pwrgd_ni = 1'b1;
    repeat (8) @(negedge clk_i);
    chk("R2", "1-cycle glitch", latched_o, 0);
    chk("R1", "glitch leaves defaults", {pair_a_sel_o, cpu_freq_o}, 0);
    pwrgd_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    pwrgd_ni = 1'b1;
    repeat (6) @(negedge clk_i);
    check_decoded(6'b010_11_1, "2-cycle low");

    // test mode re-capture then freeze
    apply(6'b101_00_0);
    do_reset();
    test_mode_i = 1'b1;
    pwrgd_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    check_decoded(6'b101_00_0, "test first");
    apply(6'b011_10_1);
    @(negedge clk_i);
    chk("R5", "test recapture", {fs_q_o, fsel_q_o, itp_q_o}, 6'b011_10_1);
    check_decoded(6'b011_10_1, "test recapture");
    apply(6'b001_01_0);
    @(negedge clk_i);
    chk("R5", "test recapture 2", {fs_q_o, fsel_q_o, itp_q_o}, 6'b001_01_0);
    test_mode_i = 1'b0;
    apply(6'b111_11_1);
    repeat (4) @(negedge clk_i);
    chk("R5", "frozen after test", {fs_q_o, fsel_q_o, itp_q_o}, 6'b001_01_0);
    chk("R4", "pair_a frozen", pair_a_sel_o, 0);

    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk_i);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule